// File: doc/BRIEF.md
# Five-Level Sine-Triangle Gate Pattern Generator

This block drives the eight gate lines of two series-stacked full bridges so that their summed output steps through five levels: minus two, minus one, zero, plus one and plus two. A sine reference is read from a table that is computed at elaboration. It is scaled by a modulation-index word and compared with an internal triangle carrier. For each clock the block picks one of the two adjacent levels that bracket the reference and places the gate pattern for that level on the output register.

With the default parameters the carrier repeats every 256 clocks. The reference steps through 256 entries, one every 40 clocks, so one reference cycle holds exactly 40 carrier cycles. This matches a 50 Hz sine against a 2 kHz carrier when the clock is 512 kHz. The modulation index is a fixed-point word in which 128 stands for 1.0. A nominal 0.8 is 102 and the lowest useful setting, 0.1, is 13.

Top module: `spwm5_gen`

## Requirements
- R1: While `rst` is high at a rising edge, that edge sets `gate_o` to 0 and `level_o` to 0, and both stay at 0 until the first edge at which `rst` is low.
- R2: The reference index j (0..255) starts at 0 after reset and advances by one every 40 clocks, wrapping after 255. The half-cycle position is q = j mod 128, and the table magnitude is mag = 255·16·p / (5·128² − 4·p) (integer division) with p = q·(128 − q).
- R3: The scaled magnitude is s = (mag · m) >> 7, where m is `mod_index` taken as an unsigned number.
- R4: When s < 128, the level magnitude is 1 if s is greater than the carrier value c, and 0 otherwise.
- R5: When s ≥ 128, the level magnitude is 2 if (s − 128) is greater than c, and 1 otherwise.
- R6: The carrier is a triangle of period 256 clocks. With n = clocks since reset mod 256, c = n for n < 128 and c = 255 − n otherwise.
- R7: Gate bits are bridge one {leg A high, leg A low, leg B high, leg B low} on bits 0..3 and bridge two on bits 4..7 in the same order. Level +1 is 8'h09, level +2 is 8'h99, level −1 is 8'h06, level −2 is 8'h66, and level 0 is 8'h00.
- R8: Reference indices 128..255 form the negative half cycle. In that half the level is negated, and `level_o` carries it as a 3-bit two's-complement value (−2 = 3'b110, −1 = 3'b111).
- R9: The two switches of one leg are never on together, and bridge two is only on with the same pattern as bridge one.
- R10: The level never moves directly from a positive value to a negative one, or the reverse, in consecutive cycles.
- R11: A `mod_index` above 128 acts as 128.
- R12: The outputs are registered. The values shown after rising edge k (counting from 1 after reset) come from the counter state after k − 1 edges and from `mod_index` as sampled at edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_index | input | 8 | Modulation index, 128 = 1.0 |
| gate_o | output | 8 | Gate lines of the two bridges |
| level_o | output | 3 | Selected level, two's complement |

## Verification
The bench runs a full reference cycle, 10240 clocks, for each of several index values and compares every cycle with an arithmetic model. Full scale exercises both comparison bands and the crossover at half scale. The nominal 0.8 and a 0.5 setting show how the band split moves with the index. The low 0.1 setting never leaves the lower band, zero must hold all gates off, and an over-range index must match the full-scale result. Resets at start-up and in the middle of a run show that the counters restart from zero.

// File: rtl/spwm5_pkg.sv
package spwm5_pkg;

    typedef enum logic [2:0] {
        LV_ZERO = 3'b000,
        LV_POS1 = 3'b001,
        LV_POS2 = 3'b010,
        LV_NEG2 = 3'b110,
        LV_NEG1 = 3'b111
    } level_e;

    localparam logic [3:0] LEG_POS = 4'b1001;
    localparam logic [3:0] LEG_NEG = 4'b0110;

    // Rational sine approximation over a half cycle of half_n steps.
    function automatic int sine_mag(input int q, input int half_n, input int full);
        int p;
        p = q * (half_n - q);
        return (full * 16 * p) / (5 * half_n * half_n - 4 * p);
    endfunction

    function automatic level_e make_level(input logic neg, input logic [1:0] m);
        level_e r;
        case (m)
            2'd1:    r = neg ? LV_NEG1 : LV_POS1;
            2'd2:    r = neg ? LV_NEG2 : LV_POS2;
            default: r = LV_ZERO;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] gates_of(input level_e l);
        logic [7:0] g;
        case (l)
            LV_POS1: g = {4'b0000, LEG_POS};
            LV_POS2: g = {LEG_POS, LEG_POS};
            LV_NEG1: g = {4'b0000, LEG_NEG};
            LV_NEG2: g = {LEG_NEG, LEG_NEG};
            default: g = 8'h00;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/spwm5_carrier.sv
module spwm5_carrier #(
    parameter int CAR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CAR_W-1:0] car_o
);
    logic [CAR_W:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= '0;
        else     ph_q <= ph_q + 1'b1;
    end

    // Rising half counts up, falling half mirrors it.
    assign car_o = ph_q[CAR_W] ? ~ph_q[CAR_W-1:0] : ph_q[CAR_W-1:0];
endmodule

// File: rtl/spwm5_reference.sv
module spwm5_reference
    import spwm5_pkg::*;
#(
    parameter int TABLE_W    = 8,
    parameter int AMP_W      = 8,
    parameter int MI_W       = 8,
    parameter int STEP_TICKS = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MI_W-1:0]  mi_i,
    output logic [AMP_W-1:0] mag_o,
    output logic             neg_o
);
    localparam int HALF   = 2 ** (TABLE_W - 1);
    localparam int FULL   = 2 ** AMP_W - 1;
    localparam int TICK_W = $clog2(STEP_TICKS);
    localparam int PROD_W = AMP_W + MI_W;
    localparam logic [MI_W-1:0] MI_ONE = MI_W'(2 ** (MI_W - 1));

    logic [TICK_W-1:0]  tick_q;
    logic [TABLE_W-1:0] idx_q;
    logic [AMP_W-1:0]   rom [HALF];
    logic [MI_W-1:0]    mi_sat;
    logic [PROD_W-1:0]  prod;

    for (genvar i = 0; i < HALF; i++) begin : g_rom
        assign rom[i] = AMP_W'(sine_mag(i, HALF, FULL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            idx_q  <= '0;
        end else if (tick_q == TICK_W'(STEP_TICKS - 1)) begin
            tick_q <= '0;
            idx_q  <= idx_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign mi_sat = (mi_i > MI_ONE) ? MI_ONE : mi_i;
    assign prod   = PROD_W'(rom[idx_q[TABLE_W-2:0]]) * PROD_W'(mi_sat);
    assign mag_o  = AMP_W'(prod >> (MI_W - 1));
    assign neg_o  = idx_q[TABLE_W-1];
endmodule

// File: rtl/spwm5_slicer.sv
module spwm5_slicer
    import spwm5_pkg::*;
#(
    parameter int CAR_W = 7
) (
    input  logic [CAR_W:0]   mag_i,
    input  logic             neg_i,
    input  logic [CAR_W-1:0] car_i,
    output level_e           lvl_o
);
    logic       upper;
    logic       above;
    logic [1:0] m;

    // Top bit picks the band; the remaining bits are the offset inside it.
    assign upper = mag_i[CAR_W];
    assign above = mag_i[CAR_W-1:0] > car_i;
    assign m     = upper ? (above ? 2'd2 : 2'd1) : (above ? 2'd1 : 2'd0);
    assign lvl_o = make_level(neg_i, m);
endmodule

// File: rtl/spwm5_gen.sv
module spwm5_gen
    import spwm5_pkg::*;
#(
    parameter int TABLE_W    = 8,
    parameter int CAR_W      = 7,
    parameter int MI_W       = 8,
    parameter int STEP_TICKS = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [MI_W-1:0] mod_index,
    output logic [7:0]      gate_o,
    output logic [2:0]      level_o
);
    localparam int AMP_W = CAR_W + 1;

    logic [CAR_W-1:0] car;
    logic [AMP_W-1:0] mag;
    logic             neg;
    level_e           lvl_d;
    level_e           lvl_q;
    logic [7:0]       gate_q;

    spwm5_carrier #(.CAR_W(CAR_W)) u_car (
        .clk   (clk),
        .rst   (rst),
        .car_o (car)
    );

    spwm5_reference #(
        .TABLE_W    (TABLE_W),
        .AMP_W      (AMP_W),
        .MI_W       (MI_W),
        .STEP_TICKS (STEP_TICKS)
    ) u_ref (
        .clk   (clk),
        .rst   (rst),
        .mi_i  (mod_index),
        .mag_o (mag),
        .neg_o (neg)
    );

    spwm5_slicer #(.CAR_W(CAR_W)) u_slice (
        .mag_i (mag),
        .neg_i (neg),
        .car_i (car),
        .lvl_o (lvl_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= LV_ZERO;
            gate_q <= '0;
        end else begin
            lvl_q  <= lvl_d;
            gate_q <= gates_of(lvl_d);
        end
    end

    assign gate_o  = gate_q;
    assign level_o = lvl_q;
endmodule

// File: rtl/spwm5_gen_chk.sv
module spwm5_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] gate_o,
    input logic [2:0] level_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (gate_o == 8'h00 && level_o == 3'b000));

    a_r9_leg_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3]) &&
        !(gate_o[4] && gate_o[5]) && !(gate_o[6] && gate_o[7]));

    a_r9_bridge2_follows: assert property (@(posedge clk) disable iff (rst)
        (gate_o[7:4] != 4'h0) |-> (gate_o[7:4] == gate_o[3:0]));

    a_r8_level_legal: assert property (@(posedge clk) disable iff (rst)
        level_o != 3'b011 && level_o != 3'b100 && level_o != 3'b101);

    a_r7_zero_all_off: assert property (@(posedge clk) disable iff (rst)
        (level_o == 3'b000) |-> (gate_o == 8'h00));

    a_r7_active_count: assert property (@(posedge clk) disable iff (rst)
        (level_o != 3'b000) |-> ($countones(gate_o) == 2 || $countones(gate_o) == 4));

    a_r10_pos_not_to_neg: assert property (@(posedge clk) disable iff (rst)
        (!$past(level_o[2]) && $past(level_o) != 3'b000) |-> !level_o[2]);

    a_r10_neg_not_to_pos: assert property (@(posedge clk) disable iff (rst)
        $past(level_o[2]) |-> (level_o[2] || level_o == 3'b000));
endmodule

bind spwm5_gen spwm5_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .gate_o  (gate_o),
    .level_o (level_o)
);

// File: tb/test_spwm5_gen.sv
module test_spwm5_gen;
    localparam int CLK_PERIOD = 10;
    localparam int REF_CYCLE  = 256 * 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mod_index = 8'd0;
    logic [7:0] gate_o;
    logic [2:0] level_o;

    int checks   = 0;
    int failures = 0;

    spwm5_gen i_spwm5_gen (
        .clk       (clk),
        .rst       (rst),
        .mod_index (mod_index),
        .gate_o    (gate_o),
        .level_o   (level_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int exp_level(input int j, input int mi, output int s);
        int n, c, idx, q, p, mag, m, lv;
        n   = j % 256;
        c   = (n < 128) ? n : 255 - n;              // R6
        idx = (j / 40) % 256;                       // R2
        q   = idx % 128;
        p   = q * (128 - q);
        mag = (255 * 16 * p) / (5 * 128 * 128 - 4 * p);
        m   = mi;                                   // R3 / R11
        s   = (mag * m) >> 7;
        if (s < 128) lv = (s > c) ? 1 : 0;          // R4
        else         lv = ((s - 128) > c) ? 2 : 1;  // R5
        if (idx >= 128) lv = -lv;                   // R8
        return lv;
    endfunction

    function automatic logic [7:0] exp_gates(input int lv);
        case (lv)
            1:  return 8'h09;
            2:  return 8'h99;
            -1: return 8'h06;
            -2: return 8'h66;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check_reset(input string where);
        checks++;
        if (gate_o !== 8'h00 || level_o !== 3'b000) begin
            failures++;
            $display("FAIL R1 %s: gate=%h level=%b expected gate=00 level=000",
                     where, gate_o, level_o);
        end
    endtask

    // One full reference cycle, each output sampled at the falling edge after
    // the rising edge that loads it (R12): after edge k the model uses j = k-1.
    task automatic sweep(input int mi, input int eff_mi);
        rst = 1'b1;
        mod_index = 8'(mi);
        @(posedge clk);
        @(negedge clk);
        check_reset("before sweep");
        rst = 1'b0;
        for (int k = 1; k <= REF_CYCLE; k++) begin
            int s, lv;
            string tag;
            @(posedge clk);
            @(negedge clk);
            lv = exp_level(k - 1, eff_mi, s);
            if (mi > 128)    tag = "R11";
            else if (s < 128) tag = "R4";
            else             tag = "R5";
            checks++;
            if ($signed(level_o) != lv) begin
                failures++;
                $display("FAIL %s mi=%0d j=%0d: level=%0d expected %0d",
                         tag, mi, k - 1, $signed(level_o), lv);
            end
            checks++;
            if (gate_o !== exp_gates(lv)) begin
                failures++;
                $display("FAIL R7 mi=%0d j=%0d: gate=%h expected %h",
                         mi, k - 1, gate_o, exp_gates(lv));
            end
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_reset("power-on");

        sweep(128, 128);   // full scale: both bands
        sweep(102, 102);   // nominal 0.8
        sweep(64, 64);     // 0.5: peak just at half scale
        sweep(13, 13);     // 0.1: lower band only
        sweep(0, 0);       // no output at all
        sweep(200, 128);   // R11: saturates to full scale

        // Reset in the middle of a run restarts the counters (R1, R2, R6).
        mod_index = 8'd128;
        repeat (3000) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset("mid-run");
        rst = 1'b0;
        for (int k = 1; k <= 600; k++) begin
            int s, lv;
            @(posedge clk);
            @(negedge clk);
            lv = exp_level(k - 1, 128, s);
            checks++;
            if ($signed(level_o) != lv || gate_o !== exp_gates(lv)) begin
                failures++;
                $display("FAIL R2 restart j=%0d: level=%0d gate=%h expected %0d %h",
                         k - 1, $signed(level_o), gate_o, lv, exp_gates(lv));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule